// File: doc/BRIEF.md
# Dual wiper register bank controller

This block holds the digital state behind two 64-position potentiometers. Each channel has a volatile wiper register that selects one tap of its switch array. It also has four data registers that stand in for nonvolatile storage. The wiper register drives a one-hot tap-select vector, and exactly one switch is closed at any time. While reset is held, each wiper is loaded from data register 0 of its channel. That value is in place on the first cycle after reset is released.

A host talks to the block through a command stream. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The host must hold a command steady until it is taken. A command shown while `cmd_ready` is low is not taken and has no effect. `cmd_ready` is low during reset and while a modelled nonvolatile write is busy. The read response is a one-cycle `rsp_valid` pulse with no back-pressure.

The data registers are not touched by reset; only the `INIT_DR` parameter gives their first contents. An active-low write-protect input blocks the two commands that write a data register. Writes to the wiper stay allowed while it is low. A blocked command raises a sticky error flag.

Top module: `dual_wiper_bank`

## Requirements
- R1: While `rst` is high, each channel's wiper is loaded from its data register 0. From then on, channel i's slice `tap_sel[i*64 +: 64]` always has exactly one bit set, and that bit's index equals the wiper value.
- R2: An accepted opcode 0 (read wiper) or opcode 1 (read the data register chosen by `cmd_reg`) raises `rsp_valid` for one cycle on the cycle after acceptance. `rsp_data` then holds the value, zero-extended to 8 bits. No other opcode raises `rsp_valid`.
- R3: An accepted opcode 2 loads `cmd_data[5:0]` into the wiper and ignores `cmd_data[7:6]`. When no command is accepted, the tap select holds still.
- R4: An accepted opcode 3 with `wp_n` high stores `cmd_data[5:0]` in the chosen data register and leaves the wiper unchanged.
- R5: An accepted opcode 4 copies the chosen data register into the wiper. An accepted opcode 5 with `wp_n` high copies the wiper into the chosen data register.
- R6: An accepted opcode 3 or 5 with `wp_n` high drives `cmd_ready` low for exactly `BUSY_CYCLES` cycles. A command shown during that window is not taken.
- R7: With `wp_n` low, opcode 3 and opcode 5 are rejected. The data register is unchanged, no busy window starts and `err_flag` is set. Opcodes 2 and 4 still change the wiper.
- R8: `err_flag` stays set until the next accepted command that is not rejected, or until reset, and either one clears it.
- R9: Reset leaves the data registers unchanged. `INIT_DR` packs channel c, register r at bits `(c*4+r)*6 +: 6`.
- R10: A command changes only the channel chosen by `cmd_chan` (0 or 1).
- R11: Opcodes 6 and 7 are accepted and change no register. Their only effect is to clear `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the control logic, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_chan | input | 1 | Channel select |
| cmd_reg | input | 2 | Data register select |
| cmd_op | input | 3 | Opcode (0..7) |
| cmd_data | input | 8 | Write data; only the low 6 bits are used |
| wp_n | input | 1 | Write protect, active low, blocks data register writes |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Read data |
| err_flag | output | 1 | Sticky flag for a rejected write |
| tap_sel | output | 128 | One-hot tap selects, 64 per channel |

## Verification
The bench counts the cycles that `cmd_ready` stays low after a nonvolatile write. A counter that is off by one shows up as a wrong count. The bench also shows a command during the busy window and then reads the wiper back; a design that took that command would report the new value. Writes are issued with protect low and the data register is read back. A design that gated all writes would freeze the wiper, and one that gated none would change the stored value or never set the error flag. The bench resets after changing data register 0 and checks that the wiper comes back to the new value and that other data registers are kept. It also drives the tap select to both extreme positions, uses the unused opcodes, and sets the two top data bits.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  typedef enum logic [2:0] {
    OP_RD_WCR = 3'd0,
    OP_RD_DR  = 3'd1,
    OP_WR_WCR = 3'd2,
    OP_WR_DR  = 3'd3,
    OP_DR2WCR = 3'd4,
    OP_WCR2DR = 3'd5,
    OP_NOP6   = 3'd6,
    OP_NOP7   = 3'd7
  } dwb_op_e;

  function automatic logic dwb_is_nv(dwb_op_e op);
    return (op == OP_WR_DR) || (op == OP_WCR2DR);
  endfunction

  function automatic logic dwb_is_rd(dwb_op_e op);
    return (op == OP_RD_WCR) || (op == OP_RD_DR);
  endfunction
endpackage

// File: rtl/dwb_tap_dec.sv
module dwb_tap_dec #(
  parameter int TAPS = 64,
  localparam int W = $clog2(TAPS)
) (
  input  logic [W-1:0]    pos,
  output logic [TAPS-1:0] tap
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap[t] = (pos == W'(t));
  end
endmodule

// File: rtl/dwb_channel.sv
module dwb_channel
  import dwb_pkg::*;
#(
  parameter int TAPS = 64,
  parameter int NDR  = 4,
  localparam int W   = $clog2(TAPS),
  localparam int RW  = $clog2(NDR),
  parameter logic [NDR*W-1:0] INIT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  dwb_op_e         op,
  input  logic [RW-1:0]   rsel,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    wcr_o,
  output logic [W-1:0]    dr_o,
  output logic [TAPS-1:0] tap_o
);
  logic [NDR-1:0][W-1:0] dr_q = INIT;
  logic [W-1:0]          wcr_q;

  always_ff @(posedge clk) begin
    if (en && op == OP_WR_DR)       dr_q[rsel] <= wdata;
    else if (en && op == OP_WCR2DR) dr_q[rsel] <= wcr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcr_q <= dr_q[0];
    end else if (en) begin
      case (op)
        OP_WR_WCR: wcr_q <= wdata;
        OP_DR2WCR: wcr_q <= dr_q[rsel];
        default:   ;
      endcase
    end
  end

  assign wcr_o = wcr_q;
  assign dr_o  = dr_q[rsel];

  dwb_tap_dec #(.TAPS(TAPS)) u_dec (.pos(wcr_q), .tap(tap_o));
endmodule

// File: rtl/dwb_ctrl.sv
module dwb_ctrl
  import dwb_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  localparam int CNTW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_valid,
  input  dwb_op_e op,
  input  logic    wp_n,
  output logic    cmd_ready,
  output logic    do_cmd,
  output logic    do_read,
  output logic    err_flag
);
  logic [CNTW-1:0] cnt_q;
  logic            busy, accept, nv, reject;

  assign busy      = (cnt_q != '0);
  assign cmd_ready = !rst && !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign nv        = dwb_is_nv(op);
  assign reject    = accept && nv && !wp_n;
  assign do_cmd    = accept && !reject;
  assign do_read   = do_cmd && dwb_is_rd(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      err_flag <= 1'b0;
    end else begin
      if (do_cmd && nv) cnt_q <= CNTW'(BUSY_CYCLES);
      else if (busy)    cnt_q <= cnt_q - 1'b1;
      if (reject)       err_flag <= 1'b1;
      else if (do_cmd)  err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_wiper_bank.sv
module dual_wiper_bank
  import dwb_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int TAPS        = 64,
  parameter int NDR         = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 8,
  localparam int W          = $clog2(TAPS),
  localparam int RW         = $clog2(NDR),
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1,
  parameter logic [NCH*NDR*W-1:0] INIT_DR = {
    6'd32, 6'd1, 6'd0, 6'd40,
    6'd63, 6'd20, 6'd10, 6'd5}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [CHW-1:0]      cmd_chan,
  input  logic [RW-1:0]       cmd_reg,
  input  logic [2:0]          cmd_op,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic                wp_n,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                err_flag,
  output logic [NCH*TAPS-1:0] tap_sel
);
  dwb_op_e      op;
  logic         do_cmd, do_read;
  logic [W-1:0] wcr_a [NCH];
  logic [W-1:0] dr_a  [NCH];

  assign op = dwb_op_e'(cmd_op);

  dwb_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .op(op), .wp_n(wp_n),
    .cmd_ready(cmd_ready), .do_cmd(do_cmd), .do_read(do_read),
    .err_flag(err_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dwb_channel #(
      .TAPS(TAPS), .NDR(NDR),
      .INIT(INIT_DR[i*NDR*W +: NDR*W])
    ) u_ch (
      .clk(clk), .rst(rst),
      .en(do_cmd && (cmd_chan == CHW'(i))),
      .op(op), .rsel(cmd_reg), .wdata(cmd_data[W-1:0]),
      .wcr_o(wcr_a[i]), .dr_o(dr_a[i]),
      .tap_o(tap_sel[i*TAPS +: TAPS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= do_read;
      if (do_read)
        rsp_data <= DATA_W'((op == OP_RD_WCR) ? wcr_a[cmd_chan] : dr_a[cmd_chan]);
    end
  end
endmodule

// File: rtl/dwb_chk.sv
module dwb_chk #(
  parameter int NCH         = 2,
  parameter int TAPS        = 64,
  parameter int BUSY_CYCLES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [2:0]          cmd_op,
  input logic                wp_n,
  input logic                rsp_valid,
  input logic                err_flag,
  input logic [NCH*TAPS-1:0] tap_sel
);
  logic acc, acc_nv;
  assign acc    = cmd_valid && cmd_ready;
  assign acc_nv = acc && (cmd_op == 3'd3 || cmd_op == 3'd5);

  for (genvar i = 0; i < NCH; i++) begin : g_oh
    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(tap_sel[i*TAPS +: TAPS]) == 1); // R1
  end

  AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op <= 3'd1) |=> rsp_valid); // R2

  AST_NO_RSP: assert property (@(posedge clk) disable iff (rst)
    !(acc && cmd_op <= 3'd1) |=> !rsp_valid); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(tap_sel)); // R3

  AST_NV_BUSY: assert property (@(posedge clk) disable iff (rst)
    (acc_nv && wp_n && BUSY_CYCLES > 0) |=> !cmd_ready); // R6

  AST_WP_REJECT: assert property (@(posedge clk) disable iff (rst)
    (acc_nv && !wp_n) |=> (err_flag && cmd_ready)); // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (acc && !(acc_nv && !wp_n)) |=> !err_flag); // R8
endmodule

bind dual_wiper_bank dwb_chk #(.NCH(NCH), .TAPS(TAPS), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .wp_n(wp_n), .rsp_valid(rsp_valid),
  .err_flag(err_flag), .tap_sel(tap_sel)
);

// File: tb/sim_dual_wiper_bank.sv
module sim_dual_wiper_bank;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [0:0]   cmd_chan = '0;
  logic [1:0]   cmd_reg = '0;
  logic [2:0]   cmd_op = '0;
  logic [7:0]   cmd_data = '0;
  logic         wp_n = 1'b1;
  logic         rsp_valid;
  logic [7:0]   rsp_data;
  logic         err_flag;
  logic [127:0] tap_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wiper_bank #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_reg(cmd_reg), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .wp_n(wp_n), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .err_flag(err_flag), .tap_sel(tap_sel)
  );

  typedef struct packed {
    logic [0:0] ch;
    logic [1:0] rs;
    logic [2:0] op;
    logic [7:0] d;
    logic       wp;
    logic       rv;
    logic [7:0] ed;
    logic       ee;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 3'd0, 8'd0,   1'b1, 1'b1, 8'd5,  1'b0}, // R1 recall ch0
    '{1'b1, 2'd0, 3'd0, 8'd0,   1'b1, 1'b1, 8'd40, 1'b0}, // R1 recall ch1
    '{1'b0, 2'd3, 3'd1, 8'd0,   1'b1, 1'b1, 8'd63, 1'b0}, // R2 R9 init DR3
    '{1'b0, 2'd0, 3'd2, 8'hC7,  1'b1, 1'b0, 8'd0,  1'b0}, // R3 write wiper
    '{1'b0, 2'd0, 3'd0, 8'd0,   1'b1, 1'b1, 8'd7,  1'b0}, // R3 high bits dropped
    '{1'b1, 2'd2, 3'd3, 8'd33,  1'b1, 1'b0, 8'd0,  1'b0}, // R4 write DR
    '{1'b1, 2'd2, 3'd1, 8'd0,   1'b1, 1'b1, 8'd33, 1'b0}, // R4 readback
    '{1'b1, 2'd2, 3'd4, 8'd0,   1'b1, 1'b0, 8'd0,  1'b0}, // R5 DR to wiper
    '{1'b1, 2'd0, 3'd0, 8'd0,   1'b1, 1'b1, 8'd33, 1'b0}, // R5 readback
    '{1'b0, 2'd1, 3'd5, 8'd0,   1'b1, 1'b0, 8'd0,  1'b0}, // R5 wiper to DR
    '{1'b0, 2'd1, 3'd1, 8'd0,   1'b1, 1'b1, 8'd7,  1'b0}, // R5 readback
    '{1'b0, 2'd3, 3'd3, 8'd1,   1'b0, 1'b0, 8'd0,  1'b1}, // R7 rejected
    '{1'b0, 2'd3, 3'd1, 8'd0,   1'b0, 1'b1, 8'd63, 1'b0}, // R7 R8 kept, err cleared
    '{1'b0, 2'd0, 3'd2, 8'd50,  1'b0, 1'b0, 8'd0,  1'b0}, // R7 wiper write allowed
    '{1'b0, 2'd0, 3'd0, 8'd0,   1'b0, 1'b1, 8'd50, 1'b0}, // R7 readback
    '{1'b1, 2'd0, 3'd5, 8'd0,   1'b0, 1'b0, 8'd0,  1'b1}, // R7 copy rejected
    '{1'b1, 2'd0, 3'd1, 8'd0,   1'b1, 1'b1, 8'd40, 1'b0}, // R7 DR0 kept
    '{1'b1, 2'd0, 3'd0, 8'd0,   1'b1, 1'b1, 8'd33, 1'b0}  // R10 ch1 untouched
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  // Drive one command; returns at the negedge after acceptance.
  task automatic issue(input logic [0:0] ch, input logic [1:0] rs, input logic [2:0] op,
                       input logic [7:0] d, input logic wp);
    wait_ready();
    cmd_chan = ch; cmd_reg = rs; cmd_op = op; cmd_data = d; wp_n = wp;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [0:0] ch, input logic [1:0] rs,
                          input logic [2:0] op, input logic [7:0] exp);
    issue(ch, rs, op, 8'd0, 1'b1);
    check({tag, " rsp_valid"}, 128'(rsp_valid), 128'd1);
    check({tag, " rsp_data"}, 128'(rsp_data), 128'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 ready low in reset", 128'(cmd_ready), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset ready", 128'(cmd_ready), 128'd1);
    check("R8 reset err", 128'(err_flag), 128'd0);
    check("R2 reset rsp_valid", 128'(rsp_valid), 128'd0);
    check("R1 reset tap ch0", 128'(tap_sel[63:0]), 128'(64'd1 << 5));
    check("R1 reset tap ch1", 128'(tap_sel[127:64]), 128'(64'd1 << 40));

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].ch, VEC[k].rs, VEC[k].op, VEC[k].d, VEC[k].wp);
      check($sformatf("R2 vec%0d rsp_valid", k), 128'(rsp_valid), 128'(VEC[k].rv));
      if (VEC[k].rv)
        check($sformatf("R2 vec%0d rsp_data", k), 128'(rsp_data), 128'(VEC[k].ed));
      check($sformatf("R8 vec%0d err", k), 128'(err_flag), 128'(VEC[k].ee));
    end

    check("R10 tap ch0", 128'(tap_sel[63:0]), 128'(64'd1 << 50));
    check("R10 tap ch1", 128'(tap_sel[127:64]), 128'(64'd1 << 33));

    // R6: busy window length and command ignored while busy
    begin
      int n;
      issue(1'b0, 2'd2, 3'd3, 8'd9, 1'b1);
      cmd_op = 3'd2; cmd_data = 8'd60; cmd_chan = 1'b0;
      cmd_valid = 1'b1;
      n = 0;
      while (!cmd_ready) begin
        n++;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      check("R6 busy cycles", 128'(n), 128'(BUSY));
    end
    read_chk("R6 busy cmd ignored", 1'b0, 2'd0, 3'd0, 8'd50);
    read_chk("R4 DR2 stored", 1'b0, 2'd2, 3'd1, 8'd9);

    // R1: tap extremes
    issue(1'b0, 2'd0, 3'd2, 8'd63, 1'b1);
    check("R1 tap top", 128'(tap_sel[63:0]), 128'(64'd1 << 63));
    issue(1'b0, 2'd0, 3'd2, 8'd0, 1'b1);
    check("R1 tap bottom", 128'(tap_sel[63:0]), 128'd1);

    // R11: unused opcode changes nothing
    issue(1'b0, 2'd0, 3'd6, 8'd44, 1'b1);
    check("R11 no rsp", 128'(rsp_valid), 128'd0);
    read_chk("R11 wiper kept", 1'b0, 2'd0, 3'd0, 8'd0);

    // R8: sticky error, then cleared by opcode 7
    issue(1'b1, 2'd1, 3'd3, 8'd12, 1'b0);
    repeat (5) @(negedge clk);
    check("R8 err sticky", 128'(err_flag), 128'd1);
    check("R7 no busy on reject", 128'(cmd_ready), 128'd1);
    issue(1'b0, 2'd0, 3'd7, 8'd0, 1'b1);
    check("R11 R8 nop clears err", 128'(err_flag), 128'd0);
    read_chk("R7 ch1 DR1 kept", 1'b1, 2'd1, 3'd1, 8'd0);

    // R9: data registers survive reset, DR0 recalled
    issue(1'b0, 2'd0, 3'd3, 8'd22, 1'b1);
    wait_ready();
    issue(1'b0, 2'd0, 3'd3, 8'd1, 1'b0);
    check("R7 err before reset", 128'(err_flag), 128'd1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 err after reset", 128'(err_flag), 128'd0);
    check("R1 R9 recall new DR0", 128'(tap_sel[63:0]), 128'(64'd1 << 22));
    check("R1 recall ch1", 128'(tap_sel[127:64]), 128'(64'd1 << 40));
    read_chk("R9 DR2 kept", 1'b0, 2'd2, 3'd1, 8'd9);
    read_chk("R9 DR1 kept", 1'b0, 2'd1, 3'd1, 8'd7);
    read_chk("R9 ch1 DR2 kept", 1'b1, 2'd2, 3'd1, 8'd33);

    finish_run();
  end
endmodule